// File: doc/BRIEF.md
# Sampling Converter Phase Sequencer

This block is the digital control core of a successive-approximation converter, run from a fast system clock. It watches four slow control pins: a conversion-start line, an active-low select, an active-low nap enable and an active-low power-down/reset line. From them it derives the internal sample, convert and nap phases and drives a busy flag. When a conversion finishes, it emits a one-cycle done strobe and latches the code presented by a stub approximation engine. A select edge during a conversion aborts it and leaves a fixed marker code in place of a result.

The power-down/reset line is classified by how long it stays low. A short pulse resets the sequencer, and operation resumes as soon as the line returns high. A long one enters power-down, and leaving it costs a fixed wake delay. After any reset, a counter flags the next few completed conversions as not trustworthy. All timing is set by parameters counted in system-clock cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy_o`, `sampling_o`, `napping_o`, `done_o`, `abort_o`, `data_valid_o` and `powered_down_o` are 0, and `result_o` is 0.
- R2: From idle, a rising edge on `convst_i` while `cs_n_i` is low starts the sample phase (`sampling_o` = 1).
- R3: From idle, a falling edge on `cs_n_i` while `convst_i` is high starts the sample phase. A select fall with `convst_i` low does not start sampling.
- R4: During sampling, a conversion starts on a `convst_i` fall with `cs_n_i` low, or on a `cs_n_i` fall with `convst_i` low. `busy_o` is then high for exactly CONV_CYC cycles. In the cycle it drops, `done_o` pulses for one cycle and `result_o` holds the value of `sar_code_i`.
- R5: If `cs_n_i` is low and `convst_i` is high when a conversion ends, sampling restarts in that same cycle, with no idle gap.
- R6: A `cs_n_i` fall while `busy_o` and `convst_i` are both high ends the conversion at once. `busy_o` drops and `abort_o` pulses with no `done_o`. `result_o` becomes the marker: all ones in the top seven bits and zeros below (0xFE0 for 12 bits). `data_valid_o` is cleared and sampling does not restart.
- R7: A conversion-start edge that arrives before the sample phase has lasted ACQ_CYC cycles is ignored, and sampling continues.
- R8: With `nap_en_n_i` low, `napping_o` is high whenever the sequencer is idle, including right after a conversion ends. A sample phase entered from nap needs ACQ_CYC + NAP_XTRA_CYC cycles before a start edge is accepted.
- R9: Driving `pdrst_n_i` low forces the idle phase. If a conversion was running, `abort_o` pulses. `result_o` takes the marker code in either case.
- R10: A low on `pdrst_n_i` shorter than PD_CYC cycles allows sampling as soon as the line is high again. A low of PD_CYC cycles or more raises `powered_down_o`, which stays high, and inputs stay ignored, for WAKE_CYC cycles after the line returns high.
- R11: Following `rst_n` release or any low on `pdrst_n_i`, the first INVALID_N completed conversions report `data_valid_o` = 0 with their result. Later completions report 1.
- R12: Every pin edge acts through SYNC_STAGES synchroniser flops plus one edge-detect stage, so its effect appears SYNC_STAGES+1 clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| convst_i | input | 1 | Conversion-start pin (asynchronous) |
| cs_n_i | input | 1 | Active-low select pin (asynchronous) |
| nap_en_n_i | input | 1 | Active-low nap enable (asynchronous) |
| pdrst_n_i | input | 1 | Active-low power-down/reset pin (asynchronous) |
| sar_code_i | input | RES_W | Code from the approximation engine, taken at conversion end |
| busy_o | output | 1 | High while a conversion runs |
| sampling_o | output | 1 | High during the sample phase |
| napping_o | output | 1 | High while idle in nap |
| done_o | output | 1 | One-cycle strobe when a conversion completes |
| abort_o | output | 1 | One-cycle strobe when a conversion is aborted |
| result_o | output | RES_W | Latest result or abort marker |
| data_valid_o | output | 1 | Trust flag for the latest result |
| powered_down_o | output | 1 | High in power-down and during the wake delay |

## Verification
A pin change shows on the phase outputs at the third clock edge after it is driven. A started conversion holds `busy_o` for CONV_CYC cycles, and `done_o` or `abort_o` appears on the edge that ends it. Power-down is flagged on edge PD_CYC+2 of a held low, and it clears on edge WAKE_CYC+3 after release. The bench drives on falling clock edges and counts falling edges to these exact positions, checking both the last cycle before each change and the first cycle after it. A scoreboard queue holds the expected done and abort events; it is matched whenever either strobe is seen.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_CONV   = 2'd2
   } phase_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else if (s == 0) stage_q[s] <= d_i;
               else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/adc_seq_pwr.sv
module adc_seq_pwr #(
   parameter int unsigned PD_CYC   = 720,
   parameter int unsigned WAKE_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   output logic hold_o,
   output logic enter_o,
   output logic pd_o
);
   localparam int unsigned LW = $clog2(PD_CYC + 1);
   localparam int unsigned WW = $clog2(WAKE_CYC + 1);

   logic          line_q;
   logic          pd_q;
   logic          waking_q;
   logic [LW-1:0] low_cnt;
   logic [WW-1:0] wake_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q   <= 1'b1;
         pd_q     <= 1'b0;
         waking_q <= 1'b0;
         low_cnt  <= '0;
         wake_cnt <= '0;
      end else begin
         line_q <= line_s;
         if (!line_s) begin
            waking_q <= 1'b0;
            wake_cnt <= '0;
            if (!pd_q) begin
               if (low_cnt == LW'(PD_CYC - 1)) pd_q <= 1'b1;
               else low_cnt <= low_cnt + 1'b1;
            end
         end else begin
            low_cnt <= '0;
            if (!line_q && pd_q) begin
               waking_q <= 1'b1;
               wake_cnt <= '0;
            end else if (waking_q) begin
               if (wake_cnt == WW'(WAKE_CYC - 1)) begin
                  waking_q <= 1'b0;
                  pd_q     <= 1'b0;
               end else begin
                  wake_cnt <= wake_cnt + 1'b1;
               end
            end
         end
      end
   end

   assign hold_o  = !line_s || waking_q || (!line_q && pd_q);
   assign enter_o = line_q && !line_s;
   assign pd_o    = pd_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W        = 12,
   parameter int unsigned CONV_CYC     = 20,
   parameter int unsigned ACQ_CYC      = 6,
   parameter int unsigned NAP_XTRA_CYC = 6,
   parameter int unsigned INVALID_N    = 4,
   parameter logic [RES_W-1:0] MARKER  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cv_s,
   input  logic             cs_s,
   input  logic             nap_n_s,
   input  logic             hold_i,
   input  logic             hold_enter_i,
   input  logic [RES_W-1:0] code_i,
   output logic             busy_o,
   output logic             sampling_o,
   output logic             napping_o,
   output logic             done_o,
   output logic             abort_o,
   output logic [RES_W-1:0] result_o,
   output logic             valid_o
);
   localparam int unsigned CW = $clog2(CONV_CYC + 1);
   localparam int unsigned AW = $clog2(ACQ_CYC + NAP_XTRA_CYC + 1);
   localparam int unsigned IW = $clog2(INVALID_N + 1);

   phase_e           phase;
   logic             cv_q, cs_q;
   logic [CW-1:0]    conv_cnt;
   logic [AW-1:0]    acq_cnt;
   logic             from_nap;
   logic [IW-1:0]    inv_cnt;
   logic             done_q, abort_q, valid_q;
   logic [RES_W-1:0] result_q;

   logic          cv_rise, cv_fall, cs_fall;
   logic [AW-1:0] acq_need;
   logic          acq_ok, samp_req, conv_req, abort_req, conv_last;

   assign cv_rise   = cv_s && !cv_q;
   assign cv_fall   = !cv_s && cv_q;
   assign cs_fall   = !cs_s && cs_q;
   assign acq_need  = from_nap ? AW'(ACQ_CYC + NAP_XTRA_CYC) : AW'(ACQ_CYC);
   assign acq_ok    = acq_cnt >= acq_need;
   assign samp_req  = (cv_rise && !cs_s) || (cs_fall && cv_s);
   assign conv_req  = ((cv_fall && !cs_s) || (cs_fall && !cv_s)) && acq_ok;
   assign abort_req = cs_fall && cv_s;
   assign conv_last = conv_cnt == CW'(CONV_CYC - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cv_q     <= 1'b0;
         cs_q     <= 1'b1;
         conv_cnt <= '0;
         acq_cnt  <= '0;
         from_nap <= 1'b0;
         inv_cnt  <= IW'(INVALID_N);
         done_q   <= 1'b0;
         abort_q  <= 1'b0;
         valid_q  <= 1'b0;
         result_q <= '0;
      end else begin
         cv_q    <= cv_s;
         cs_q    <= cs_s;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         if (hold_i) begin
            phase    <= PH_IDLE;
            from_nap <= 1'b0;
            inv_cnt  <= IW'(INVALID_N);
            valid_q  <= 1'b0;
            if (hold_enter_i) begin
               result_q <= MARKER;
               if (phase == PH_CONV) abort_q <= 1'b1;
            end
         end else begin
            unique case (phase)
               PH_IDLE: begin
                  if (samp_req) begin
                     phase    <= PH_SAMPLE;
                     acq_cnt  <= '0;
                     from_nap <= !nap_n_s;
                  end
               end
               PH_SAMPLE: begin
                  if (conv_req) begin
                     phase    <= PH_CONV;
                     conv_cnt <= '0;
                  end else if (!acq_ok) begin
                     acq_cnt <= acq_cnt + 1'b1;
                  end
               end
               PH_CONV: begin
                  if (abort_req) begin
                     phase    <= PH_IDLE;
                     abort_q  <= 1'b1;
                     result_q <= MARKER;
                     valid_q  <= 1'b0;
                  end else if (conv_last) begin
                     done_q   <= 1'b1;
                     result_q <= code_i;
                     valid_q  <= (inv_cnt == '0);
                     if (inv_cnt != '0) inv_cnt <= inv_cnt - 1'b1;
                     from_nap <= 1'b0;
                     if (!cs_s && cv_s) begin
                        phase   <= PH_SAMPLE;
                        acq_cnt <= '0;
                     end else begin
                        phase <= PH_IDLE;
                     end
                  end else begin
                     conv_cnt <= conv_cnt + 1'b1;
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   assign busy_o     = phase == PH_CONV;
   assign sampling_o = phase == PH_SAMPLE;
   assign napping_o  = (phase == PH_IDLE) && !nap_n_s && !hold_i;
   assign done_o     = done_q;
   assign abort_o    = abort_q;
   assign result_o   = result_q;
   assign valid_o    = valid_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int unsigned RES_W        = 12,
   parameter int unsigned CONV_CYC     = 20,
   parameter int unsigned ACQ_CYC      = 6,
   parameter int unsigned NAP_XTRA_CYC = 6,
   parameter int unsigned PD_CYC       = 720,
   parameter int unsigned WAKE_CYC     = 50,
   parameter int unsigned INVALID_N    = 4,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             convst_i,
   input  logic             cs_n_i,
   input  logic             nap_en_n_i,
   input  logic             pdrst_n_i,
   input  logic [RES_W-1:0] sar_code_i,
   output logic             busy_o,
   output logic             sampling_o,
   output logic             napping_o,
   output logic             done_o,
   output logic             abort_o,
   output logic [RES_W-1:0] result_o,
   output logic             data_valid_o,
   output logic             powered_down_o
);
   localparam logic [RES_W-1:0] MARKER = {RES_W{1'b1}} << (RES_W - 7);
   localparam logic [3:0] PIN_IDLE = 4'b1110;

   generate
      if (RES_W < 8) begin : g_bad_res
         $error("adc_seq_ctrl: RES_W must be at least 8");
      end
      if (CONV_CYC < 2 || ACQ_CYC < 1) begin : g_bad_phase
         $error("adc_seq_ctrl: CONV_CYC >= 2 and ACQ_CYC >= 1 required");
      end
      if (PD_CYC < 2 || WAKE_CYC < 1 || INVALID_N < 1) begin : g_bad_pwr
         $error("adc_seq_ctrl: PD_CYC >= 2, WAKE_CYC >= 1, INVALID_N >= 1 required");
      end
   endgenerate

   logic [3:0] pins_s;
   logic       hold, hold_enter, pd;

   adc_seq_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({pdrst_n_i, nap_en_n_i, cs_n_i, convst_i}),
      .q_o   (pins_s)
   );

   adc_seq_pwr #(.PD_CYC(PD_CYC), .WAKE_CYC(WAKE_CYC)) u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_s  (pins_s[3]),
      .hold_o  (hold),
      .enter_o (hold_enter),
      .pd_o    (pd)
   );

   adc_seq_fsm #(
      .RES_W(RES_W), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC),
      .NAP_XTRA_CYC(NAP_XTRA_CYC), .INVALID_N(INVALID_N), .MARKER(MARKER)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cv_s         (pins_s[0]),
      .cs_s         (pins_s[1]),
      .nap_n_s      (pins_s[2]),
      .hold_i       (hold),
      .hold_enter_i (hold_enter),
      .code_i       (sar_code_i),
      .busy_o       (busy_o),
      .sampling_o   (sampling_o),
      .napping_o    (napping_o),
      .done_o       (done_o),
      .abort_o      (abort_o),
      .result_o     (result_o),
      .valid_o      (data_valid_o)
   );

   assign powered_down_o = pd;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int unsigned RES_W    = 12,
   parameter int unsigned CONV_CYC = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             sampling_o,
   input logic             napping_o,
   input logic             done_o,
   input logic             abort_o,
   input logic [RES_W-1:0] result_o,
   input logic             data_valid_o,
   input logic             powered_down_o
);
   localparam int unsigned BW = $clog2(CONV_CYC + 2);
   localparam logic [RES_W-1:0] ABORT_VAL = {RES_W{1'b1}} << (RES_W - 7);

   logic [BW-1:0] busy_run;
   always_ff @(posedge clk) begin
      if (!rst_n) busy_run <= '0;
      else if (busy_o) begin
         if (busy_run != BW'(CONV_CYC + 1)) busy_run <= busy_run + 1'b1;
      end else busy_run <= '0;
   end

   // R4: sample and convert phases never overlap
   assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && sampling_o));

   // R4: a completion follows exactly CONV_CYC busy cycles
   assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_run == BW'(CONV_CYC)) && !busy_o);

   // R6: an abort carries the marker and no completion
   assert_abort_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (result_o == ABORT_VAL) && !busy_o && !done_o && !data_valid_o);

   // R11: the trust flag only rises with a completion
   assert_valid_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid_o) |-> done_o);

   // R10: nothing runs while powered down or waking
   assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      powered_down_o |-> !busy_o && !sampling_o && !napping_o);

   // R8: nap only while idle
   assert_nap_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      napping_o |-> !busy_o && !sampling_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy_o         (busy_o),
   .sampling_o     (sampling_o),
   .napping_o      (napping_o),
   .done_o         (done_o),
   .abort_o        (abort_o),
   .result_o       (result_o),
   .data_valid_o   (data_valid_o),
   .powered_down_o (powered_down_o)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int RES_W = 12;
   localparam int CONV = 20;
   localparam int ACQ = 6;
   localparam int NAPX = 6;
   localparam int PDC = 720;
   localparam int WAKE = 50;
   localparam int LAT = 3;
   localparam int WD_CYC = 20000;
   localparam logic [RES_W-1:0] MARK = 12'hFE0;

   logic clk = 1'b0;
   logic rst_n, convst, cs_n, nap_n, pdrst_n;
   logic [RES_W-1:0] sar;
   logic busy, sampling, napping, done, abort_s, dvalid, pdown;
   logic [RES_W-1:0] result;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic             is_abort;
      logic [RES_W-1:0] code;
      logic             valid;
   } exp_t;
   exp_t expq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .convst_i(convst), .cs_n_i(cs_n),
      .nap_en_n_i(nap_n), .pdrst_n_i(pdrst_n), .sar_code_i(sar),
      .busy_o(busy), .sampling_o(sampling), .napping_o(napping),
      .done_o(done), .abort_o(abort_s), .result_o(result),
      .data_valid_o(dvalid), .powered_down_o(pdown)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic ab, input logic [RES_W-1:0] c, input logic v);
      exp_t e;
      e.is_abort = ab; e.code = c; e.valid = v;
      expq.push_back(e);
   endtask

   // monitor: pops one expected event per strobe
   always @(negedge clk) begin
      if (rst_n && (done || abort_s)) begin
         checks++;
         if (expq.size() == 0) begin
            errors++;
            $display("FAIL R4/R6/R9 unexpected event: actual done=%0b abort=%0b expected none", done, abort_s);
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (abort_s !== e.is_abort || done !== !e.is_abort || result !== e.code || dvalid !== e.valid) begin
               errors++;
               $display("FAIL R4/R6/R11 event: actual abort=%0b code=%0h valid=%0b expected abort=%0b code=%0h valid=%0b",
                        abort_s, result, dvalid, e.is_abort, e.code, e.valid);
            end
         end
      end
   end

   task automatic conv_by_cv(input logic [RES_W-1:0] c, input logic v);
      push(1'b0, c, v);
      sar = c;
      convst = 1'b1;
      tick(LAT + ACQ + 2);
      convst = 1'b0;
      tick(LAT);
      chk("R4 busy after convst fall", busy, 1);
      tick(CONV + 2);
   endtask

   task automatic conv_by_cs(input logic [RES_W-1:0] c, input logic v);
      cs_n = 1'b1;
      tick(LAT + 1);
      convst = 1'b1;
      tick(LAT + 1);
      push(1'b0, c, v);
      sar = c;
      cs_n = 1'b0;
      tick(LAT);
      chk("R3 sampling after select fall", sampling, 1);
      tick(ACQ + 2);
      cs_n = 1'b1;
      tick(LAT + 1);
      convst = 1'b0;
      tick(LAT + 1);
      cs_n = 1'b0;
      tick(LAT);
      chk("R4 busy after select fall", busy, 1);
      tick(CONV + 2);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; convst = 1'b0; cs_n = 1'b1; nap_n = 1'b1; pdrst_n = 1'b1; sar = '0;
      tick(5);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 sampling", sampling, 0);
      chk("R1 napping", napping, 0);
      chk("R1 done/abort", {done, abort_s}, 0);
      chk("R1 result", result, 0);
      chk("R1 valid", dvalid, 0);
      chk("R1 powered down", pdown, 0);

      // select fall with convst low does not sample (R3)
      cs_n = 1'b0;
      tick(LAT + 1);
      chk("R3 no sample on select fall with convst low", sampling, 0);

      // R12 latency, R2 start, R4 duration
      push(1'b0, 12'h123, 1'b0);
      sar = 12'h123;
      convst = 1'b1;
      tick(2);
      chk("R12 not yet sampling", sampling, 0);
      tick(1);
      chk("R2 sampling on convst rise", sampling, 1);
      tick(ACQ + 1);
      convst = 1'b0;
      tick(2);
      chk("R12 not yet busy", busy, 0);
      tick(1);
      chk("R4 busy rises", busy, 1);
      tick(CONV - 1);
      chk("R4 busy last cycle", busy, 1);
      tick(1);
      chk("R4 busy falls", busy, 0);
      chk("R4 result code", result, 12'h123);
      tick(2);

      // R11: first four invalid, fifth valid
      conv_by_cv(12'h456, 1'b0);
      conv_by_cs(12'h789, 1'b0);
      conv_by_cv(12'hABC, 1'b0);
      conv_by_cs(12'hFFF, 1'b1);
      chk("R11 valid after fifth", dvalid, 1);

      // R5 back-to-back
      push(1'b0, 12'h321, 1'b1);
      push(1'b0, 12'h654, 1'b1);
      sar = 12'h321;
      convst = 1'b1;
      tick(LAT + ACQ + 2);
      convst = 1'b0;
      tick(5);
      convst = 1'b1;
      tick(CONV - 2);
      chk("R5 sampling at end", sampling, 1);
      chk("R5 busy low at end", busy, 0);
      sar = 12'h654;
      tick(ACQ + 2);
      convst = 1'b0;
      tick(LAT + CONV + 2);

      // R6 abort
      sar = 12'h0AA;
      convst = 1'b1;
      tick(LAT + ACQ + 2);
      convst = 1'b0;
      tick(LAT + 1);
      chk("R6 converting before abort", busy, 1);
      convst = 1'b1;
      cs_n = 1'b1;
      tick(LAT + 1);
      push(1'b1, MARK, 1'b0);
      cs_n = 1'b0;
      tick(LAT);
      chk("R6 busy dropped", busy, 0);
      chk("R6 abort strobe", abort_s, 1);
      chk("R6 no resample", sampling, 0);
      convst = 1'b0;
      tick(LAT + 2);
      chk("R6 marker held", result, MARK);

      // R7 early start ignored
      convst = 1'b1;
      tick(1);
      convst = 1'b0;
      tick(LAT + 4);
      chk("R7 still sampling", sampling, 1);
      chk("R7 no conversion", busy, 0);
      cs_n = 1'b1;
      tick(LAT + 1);
      push(1'b0, 12'h5A5, 1'b1);
      sar = 12'h5A5;
      cs_n = 1'b0;
      tick(LAT);
      chk("R7 later start accepted", busy, 1);
      tick(CONV + 2);

      // R8 nap
      nap_n = 1'b0;
      tick(LAT);
      chk("R8 napping idle", napping, 1);
      convst = 1'b1;
      tick(LAT);
      chk("R8 sampling from nap", sampling, 1);
      chk("R8 nap left", napping, 0);
      tick(ACQ + 1);
      convst = 1'b0;
      tick(LAT + 1);
      chk("R8 extra acquisition enforced", busy, 0);
      cs_n = 1'b1;
      tick(LAT + 1);
      push(1'b0, 12'h3C3, 1'b1);
      sar = 12'h3C3;
      cs_n = 1'b0;
      tick(LAT);
      chk("R8 start after long acquisition", busy, 1);
      tick(CONV + 2);
      chk("R8 nap after conversion", napping, 1);
      nap_n = 1'b1;
      tick(LAT);

      // R9 short reset during conversion
      convst = 1'b1;
      tick(LAT + ACQ + 2);
      convst = 1'b0;
      tick(LAT + 2);
      chk("R9 converting", busy, 1);
      push(1'b1, MARK, 1'b0);
      pdrst_n = 1'b0;
      tick(LAT);
      chk("R9 busy cleared", busy, 0);
      tick(1);
      pdrst_n = 1'b1;
      tick(LAT);
      chk("R10 short low no power-down", pdown, 0);
      chk("R9 marker", result, MARK);
      conv_by_cv(12'h111, 1'b0);

      // R10 long low
      pdrst_n = 1'b0;
      tick(PDC + 1);
      chk("R10 not yet powered down", pdown, 0);
      tick(1);
      chk("R10 powered down", pdown, 1);
      pdrst_n = 1'b1;
      tick(2);
      convst = 1'b1;
      tick(WAKE);
      chk("R10 wake still held", pdown, 1);
      chk("R10 input ignored while waking", sampling, 0);
      tick(1);
      chk("R10 wake done", pdown, 0);
      convst = 1'b0;
      tick(LAT + 1);
      conv_by_cv(12'h222, 1'b0);

      chk("R4 scoreboard drained", expq.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule